// File: doc/BRIEF.md
# Cascaded Serial ADC Chain Reader

This block is the host side of a chain of cascaded sampling converters that share one serial data line. Each converter's serial output feeds the tag input of the next device, and the last one drives the host. On a start request the block drops the read/convert line for a fixed number of clocks while holding chip-select low. It then watches the converter's busy line fall and rise again, and in the sampling window that follows it produces one gated burst of data clocks. During the burst it gathers every device's 16-bit word.

The burst length follows from the chain length, from whether the devices emit a leading synchronisation pulse, and from which data-clock edge is used to sample. The single null bit between adjacent words is removed and checked. When the burst ends, the block presents all words together with a one-cycle valid strobe. A framing-error flag rides on that strobe if any null bit read as one. If the conversion does not finish in time, the block abandons the transaction and pulses a timeout flag.

Top module: `daisy_adc_reader`

## Requirements
- R1: A `start` pulse while idle drives `rc_n` low for exactly CONV_LOW clocks (default 2). `cs_n` stays low at all times after reset.
- R2: No data-clock rising edge occurs until `busy` has been seen low and then high after the convert pulse.
- R3: One transaction produces exactly NDEV*16 + (NDEV-1) + SYNC_EN + RISE_SAMPLE data-clock pulses, which is 33 for two devices with neither option and 52 for three devices with both. `dclk` is low outside the burst, including while `rc_n` is low.
- R4: Inside the burst, each `dclk` high phase lasts HIGH_CYC clocks and each low phase between pulses lasts LOW_CYC clocks.
- R5: `result[16*d +: 16]` holds device d's word, where device 0 is nearest the host and arrives first, MSB first. The line value after data pulse k carries serial bit k-1. With SYNC_EN, the first pulse carries no data and is discarded. Bits are sampled on the falling edge of the carrying pulse, or on the next rising edge when RISE_SAMPLE=1.
- R6: The bit after each word except the last is a null bit and is not placed in `result`. `frame_err` is 1 with `valid` when any null bit read 1, and 0 otherwise.
- R7: If `busy` has not completed its low-then-high sequence within TIMEOUT_CYC clocks after `rc_n` returns high, `timeout_err` pulses for one clock. In that case no `valid` follows, no data clock is issued, and the block returns to idle.
- R8: `start` is ignored while a transaction is in progress, so no second convert pulse is issued during the burst.
- R9: After reset, `rc_n`=1, `dclk`=0, `valid`=0, `frame_err`=0 and `timeout_err`=0.
- R10: `valid` is a single-clock pulse for each completed burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one convert-and-read transaction |
| busy | input | 1 | Converter busy line, low during conversion |
| sdata | input | 1 | Serial data from the device nearest the host |
| cs_n | output | 1 | Chip-select to all devices, held low |
| rc_n | output | 1 | Read/convert line, low pulse starts a conversion |
| dclk | output | 1 | Gated external data clock |
| result | output | NDEV*16 | Gathered words, device 0 in the low bits |
| valid | output | 1 | One-clock strobe marking `result` fresh |
| frame_err | output | 1 | Some null bit was nonzero, qualified by `valid` |
| timeout_err | output | 1 | One-clock pulse when a conversion never completed |

## Verification
A wrong pulse counter or skip count shows up at once in the pulse total of a burst. It also shifts every word in `result` by one or more bit positions on the very next `valid`, and it moves the null-bit slot, so a spurious `frame_err` appears. A phase counter off by one changes the measured high or low width on the first pulse of a burst. A sequencer that leaves the wait state early shows as a data-clock edge while `busy` is low. A sequencer that never leaves it shows as a missing `valid` or a late `timeout_err`, which is found within one timeout window.

// File: rtl/daisy_adc_reader.sv
module daisy_adc_reader #(
  parameter int NDEV        = 2,
  parameter int WORD_W      = 16,
  parameter int SYNC_EN     = 0,
  parameter int RISE_SAMPLE = 0,
  parameter int CONV_LOW    = 2,
  parameter int HIGH_CYC    = 2,
  parameter int LOW_CYC     = 2,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   busy,
  input  logic                   sdata,
  output logic                   cs_n,
  output logic                   rc_n,
  output logic                   dclk,
  output logic [NDEV*WORD_W-1:0] result,
  output logic                   valid,
  output logic                   frame_err,
  output logic                   timeout_err
);
  localparam int FRAME_W = NDEV*WORD_W + NDEV - 1;
  localparam int SKIP    = SYNC_EN + RISE_SAMPLE;
  localparam int PULSES  = FRAME_W + SKIP;
  localparam int PW      = $clog2(PULSES + 1);
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);
  localparam int MAXPH   = (CONV_LOW > HIGH_CYC) ? ((CONV_LOW > LOW_CYC) ? CONV_LOW : LOW_CYC)
                                                 : ((HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC);
  localparam int PHW     = $clog2(MAXPH + 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_WAIT, S_READ, S_DONE} state_t;

  state_t                 st;
  logic [PHW-1:0]         tmr;
  logic [TW-1:0]          tcnt;
  logic [PW-1:0]          pcnt;
  logic [1:0]             ecnt;
  logic                   seen_low;
  logic [FRAME_W-1:0]     frame;
  logic [NDEV*WORD_W-1:0] words;
  logic [NDEV-1:0]        nulls;
  logic                   sev;

  assign cs_n = 1'b0;

  generate
    if (RISE_SAMPLE != 0) begin : g_rise
      assign sev = (st == S_READ) && !dclk && (tmr == PHW'(LOW_CYC - 1));
    end else begin : g_fall
      assign sev = (st == S_READ) && dclk && (tmr == PHW'(HIGH_CYC - 1));
    end
  endgenerate

  for (genvar d = 0; d < NDEV; d++) begin : g_word
    assign words[d*WORD_W +: WORD_W] = frame[FRAME_W-1-d*(WORD_W+1) -: WORD_W];
    if (d < NDEV - 1) begin : g_null
      assign nulls[d] = frame[FRAME_W-1-d*(WORD_W+1)-WORD_W];
    end else begin : g_last
      assign nulls[d] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmr         <= '0;
      tcnt        <= '0;
      pcnt        <= '0;
      ecnt        <= '0;
      seen_low    <= 1'b0;
      frame       <= '0;
      rc_n        <= 1'b1;
      dclk        <= 1'b0;
      result      <= '0;
      valid       <= 1'b0;
      frame_err   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      valid       <= 1'b0;
      frame_err   <= 1'b0;
      timeout_err <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_CONV;
          rc_n <= 1'b0;
          tmr  <= '0;
        end
        S_CONV: if (tmr == PHW'(CONV_LOW - 1)) begin
          rc_n     <= 1'b1;
          st       <= S_WAIT;
          tcnt     <= '0;
          seen_low <= 1'b0;
        end else begin
          tmr <= tmr + 1'b1;
        end
        S_WAIT: begin
          tcnt <= tcnt + 1'b1;
          if (!busy) seen_low <= 1'b1;
          if (seen_low && busy) begin
            st   <= S_READ;
            tmr  <= '0;
            pcnt <= '0;
            ecnt <= '0;
            dclk <= 1'b0;
          end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end
        end
        S_READ: begin
          if (dclk) begin
            if (tmr == PHW'(HIGH_CYC - 1)) begin
              dclk <= 1'b0;
              tmr  <= '0;
              if (pcnt == PW'(PULSES)) st <= S_DONE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end else begin
            if (tmr == PHW'(LOW_CYC - 1)) begin
              dclk <= 1'b1;
              tmr  <= '0;
              pcnt <= pcnt + 1'b1;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          if (sev) begin
            if (ecnt != 2'(SKIP)) ecnt <= ecnt + 1'b1;
            else                  frame <= {frame[FRAME_W-2:0], sdata};
          end
        end
        S_DONE: begin
          valid     <= 1'b1;
          result    <= words;
          frame_err <= |nulls;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  generate
    if (CONV_LOW > 1) begin : g_conv_chk
      assert_conv_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_n) |=> !rc_n);
    end
  endgenerate

  assert_quiet_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_n |-> !dclk);

  assert_clock_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> busy);

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_timeout_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!valid && !dclk));

  assert_flag_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> valid);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> rc_n);
endmodule

// File: tb/adc_chain_model.sv
module adc_chain_model #(
  parameter int NDEV     = 2,
  parameter int SYNC_EN  = 0,
  parameter int CONV_CYC = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rc_n,
  input  logic               cs_n,
  input  logic               dclk,
  input  logic               hold,
  input  logic [NDEV*16-1:0] words,
  input  logic [NDEV-1:0]    nulls,
  output logic               busy,
  output logic               sdata,
  output int                 edges,
  output int                 early,
  output int                 conv_cnt,
  output int                 rc_low_len,
  output int                 hi_min,
  output int                 hi_max,
  output int                 lo_min,
  output int                 lo_max
);
  localparam int B = NDEV*17 - 1;
  logic strm [B];
  logic rc_q, dclk_q;
  int   cnt, rc_run, hi_run, lo_run;

  always_comb begin
    for (int d = 0; d < NDEV; d++) begin
      for (int b = 0; b < 16; b++) strm[d*17+b] = words[d*16+15-b];
      if (d < NDEV - 1) strm[d*17+16] = nulls[d];
    end
  end

  always_comb begin
    if (edges <= SYNC_EN) sdata = 1'b0;
    else if (edges - 1 - SYNC_EN < B) sdata = strm[edges-1-SYNC_EN];
    else sdata = 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1; cnt <= 0; rc_q <= 1'b1; dclk_q <= 1'b0;
      edges <= 0; early <= 0; conv_cnt <= 0; rc_low_len <= 0; rc_run <= 0;
      hi_run <= 0; lo_run <= 0; hi_min <= 999; hi_max <= 0; lo_min <= 999; lo_max <= 0;
    end else begin
      rc_q   <= rc_n;
      dclk_q <= dclk;
      if (!rc_n) rc_run <= rc_q ? 1 : rc_run + 1;
      else if (!rc_q) rc_low_len <= rc_run;
      if (rc_q && !rc_n && !cs_n) begin
        busy <= 1'b0; cnt <= CONV_CYC; conv_cnt <= conv_cnt + 1; edges <= 0;
        hi_min <= 999; hi_max <= 0; lo_min <= 999; lo_max <= 0;
      end else begin
        if (!busy) begin
          if (cnt != 0) cnt <= cnt - 1;
          else if (!hold) busy <= 1'b1;
        end
        if (dclk && !dclk_q) begin
          edges <= edges + 1;
          if (!busy) early <= early + 1;
        end
        if (dclk) hi_run <= dclk_q ? hi_run + 1 : 1;
        else if (dclk_q) begin
          if (hi_run < hi_min) hi_min <= hi_run;
          if (hi_run > hi_max) hi_max <= hi_run;
        end
        if (!dclk) lo_run <= !dclk_q ? lo_run + 1 : 1;
        else if (!dclk_q && edges > 0) begin
          if (lo_run < lo_min) lo_min <= lo_run;
          if (lo_run > lo_max) lo_max <= lo_run;
        end
      end
    end
  end
endmodule

// File: tb/tb_daisy_adc_reader.sv
module tb_daisy_adc_reader;
  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic start_a, busy_a, sdata_a, cs_a, rc_a, dclk_a, valid_a, ferr_a, terr_a, hold_a;
  logic [31:0] result_a, words_a;
  logic [1:0]  nulls_a;
  int edges_a, early_a, conv_a, rcl_a, him_a, hix_a, lom_a, lox_a;

  logic start_b, busy_b, sdata_b, cs_b, rc_b, dclk_b, valid_b, ferr_b, terr_b;
  logic [47:0] result_b, words_b;
  logic [2:0]  nulls_b;
  int edges_b, early_b, conv_b, rcl_b, him_b, hix_b, lom_b, lox_b;

  int  checks = 0, fails = 0;
  bit  finished = 0;

  daisy_adc_reader #(.TIMEOUT_CYC(200)) dut (
    .clk(clk), .rst_n(rst_n), .start(start_a), .busy(busy_a), .sdata(sdata_a),
    .cs_n(cs_a), .rc_n(rc_a), .dclk(dclk_a), .result(result_a), .valid(valid_a),
    .frame_err(ferr_a), .timeout_err(terr_a));

  adc_chain_model #(.NDEV(2), .SYNC_EN(0)) chain_a (
    .clk(clk), .rst_n(rst_n), .rc_n(rc_a), .cs_n(cs_a), .dclk(dclk_a), .hold(hold_a),
    .words(words_a), .nulls(nulls_a), .busy(busy_a), .sdata(sdata_a), .edges(edges_a),
    .early(early_a), .conv_cnt(conv_a), .rc_low_len(rcl_a), .hi_min(him_a), .hi_max(hix_a),
    .lo_min(lom_a), .lo_max(lox_a));

  daisy_adc_reader #(.NDEV(3), .SYNC_EN(1), .RISE_SAMPLE(1), .CONV_LOW(3),
                     .HIGH_CYC(3), .LOW_CYC(2), .TIMEOUT_CYC(200)) dut_b (
    .clk(clk), .rst_n(rst_n), .start(start_b), .busy(busy_b), .sdata(sdata_b),
    .cs_n(cs_b), .rc_n(rc_b), .dclk(dclk_b), .result(result_b), .valid(valid_b),
    .frame_err(ferr_b), .timeout_err(terr_b));

  adc_chain_model #(.NDEV(3), .SYNC_EN(1)) chain_b (
    .clk(clk), .rst_n(rst_n), .rc_n(rc_b), .cs_n(cs_b), .dclk(dclk_b), .hold(1'b0),
    .words(words_b), .nulls(nulls_b), .busy(busy_b), .sdata(sdata_b), .edges(edges_b),
    .early(early_b), .conv_cnt(conv_b), .rc_low_len(rcl_b), .hi_min(him_b), .hi_max(hix_b),
    .lo_min(lom_b), .lo_max(lox_b));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
  endtask

  task automatic wait_a(output bit v, output bit t, output int n);
    v = 0; t = 0; n = 0;
    while (n < 1000 && !v && !t) begin
      @(negedge clk); n++;
      if (valid_a) v = 1;
      if (terr_a) t = 1;
    end
  endtask

  task automatic t_reset();
    check("R9 rc_n idle", rc_a, 1'b1);
    check("R9 dclk idle", dclk_a, 1'b0);
    check("R9 valid idle", valid_a, 1'b0);
    check("R9 flags idle", {ferr_a, terr_a}, 2'b00);
    check("R1 cs_n low", cs_a, 1'b0);
  endtask

  task automatic read_a(logic [31:0] w, logic [1:0] nl, logic exp_err, string tag);
    bit v, t; int n;
    words_a = w; nulls_a = nl;
    pulse_a();
    wait_a(v, t, n);
    check({"R5 valid seen ", tag}, v, 1'b1);
    check({"R5 result ", tag}, result_a, w);
    check({"R6 frame_err ", tag}, ferr_a, exp_err);
    @(negedge clk);
    check({"R10 valid single ", tag}, valid_a, 1'b0);
    check({"R3 pulse count ", tag}, edges_a, 33);
    check({"R2 no early clock ", tag}, early_a, 0);
  endtask

  task automatic t_basic();
    read_a(32'h1234_A5C3, 2'b00, 1'b0, "basic");
    check("R1 convert width", rcl_a, 2);
    check("R4 high phase", {him_a[15:0], hix_a[15:0]}, {16'd2, 16'd2});
    check("R4 low phase", {lom_a[15:0], lox_a[15:0]}, {16'd2, 16'd2});
    check("R3 dclk parked", dclk_a, 1'b0);
  endtask

  task automatic t_extremes();
    read_a(32'hFFFF_0000, 2'b00, 1'b0, "ones-high");
    read_a(32'h0000_FFFF, 2'b00, 1'b0, "ones-low");
    read_a(32'h8001_7FFE, 2'b00, 1'b0, "edges");
  endtask

  task automatic t_frame();
    read_a(32'h0F0F_F0F0, 2'b01, 1'b1, "bad null");
    read_a(32'h0F0F_F0F0, 2'b00, 1'b0, "null cleared");
  endtask

  task automatic t_ignore();
    bit v, t; int n, c0;
    words_a = 32'hCAFE_BEEF; nulls_a = 2'b00;
    c0 = conv_a;
    pulse_a();
    while (edges_a < 6) @(negedge clk);
    pulse_a();
    wait_a(v, t, n);
    check("R8 one conversion", conv_a - c0, 1);
    check("R8 result intact", result_a, 32'hCAFE_BEEF);
    repeat (40) @(negedge clk);
    check("R8 no late convert", {rc_a, 31'(conv_a - c0)}, {1'b1, 31'd1});
  endtask

  task automatic t_timeout();
    bit v, t; int n;
    hold_a = 1'b1;
    pulse_a();
    wait_a(v, t, n);
    check("R7 timeout flagged", t, 1'b1);
    check("R7 no valid", v, 1'b0);
    check("R7 no clocks", edges_a, 0);
    check("R7 timing window", (n >= 200 && n <= 210), 1'b1);
    @(negedge clk);
    check("R7 single pulse", terr_a, 1'b0);
    hold_a = 1'b0;
    repeat (40) @(negedge clk);
    check("R7 idle after abort", {valid_a, dclk_a, rc_a}, 3'b001);
    read_a(32'h55AA_33CC, 2'b00, 1'b0, "after timeout");
  endtask

  task automatic t_variant();
    bit v; int n;
    words_b = 48'h9ABC_1357_E024; nulls_b = 3'b000;
    @(negedge clk) start_b = 1'b1;
    @(negedge clk) start_b = 1'b0;
    v = 0; n = 0;
    while (n < 1000 && !v) begin
      @(negedge clk); n++;
      if (valid_b) v = 1;
    end
    check("R5 sync+rise result", result_b, 48'h9ABC_1357_E024);
    check("R6 sync+rise no err", ferr_b, 1'b0);
    check("R3 sync+rise pulses", edges_b, 52);
    check("R1 convert width 3", rcl_b, 3);
    check("R4 high 3", {him_b[15:0], hix_b[15:0]}, {16'd3, 16'd3});
    check("R4 low 2", {lom_b[15:0], lox_b[15:0]}, {16'd2, 16'd2});
    check("R2 sync+rise no early", early_b, 0);
    words_b = 48'h0001_8000_FFFF; nulls_b = 3'b010;
    @(negedge clk) start_b = 1'b1;
    @(negedge clk) start_b = 1'b0;
    v = 0; n = 0;
    while (n < 1000 && !v) begin
      @(negedge clk); n++;
      if (valid_b) v = 1;
    end
    check("R5 sync+rise second", result_b, 48'h0001_8000_FFFF);
    check("R6 second null flagged", ferr_b, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_a = 0; start_b = 0; hold_a = 0;
    words_a = '0; nulls_a = '0; words_b = '0; nulls_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_extremes();
    t_frame();
    t_ignore();
    t_timeout();
    t_variant();
    summary();
    $finish;
  end
endmodule